// File: doc/BRIEF.md
# Line-Buffered 2x3 Video Upscaler

The block enlarges a low-resolution two-bit video image by whole-pixel repetition so that it sits centred inside a larger output raster. On the source side, each sampled pixel is written into a small ring of line buffers. The write address is formed from the pixel's column and the low bits of its line number. On the output side, a raster generator presents its current position. The block reads the matching source pixel back and emits it twice across and three times down.

Only four source lines are held, so the output trails the input by a few lines rather than a frame. This works because the two rasters run at the same, locked frame rate. The reader is started two to three source lines behind the writer, so it never touches a line that is still being filled. Any output position outside the scaled window, or outside active video, is black. The read path has one clock of latency, and the valid and position outputs are delayed by the same amount.

Top module: `lbuf_upscaler`

## Requirements
- R1: Pixels are 2 bits: 2'b00 black, 2'b01 low brightness, 2'b11 high brightness; the code 2'b10 is never presented with a write.
- R2: When `in_valid` is high on a `wr_clk` edge, `in_pix` is stored in ring slot `in_y[1:0]` at column `in_x` (address `{in_y[1:0], in_x}`). When `in_valid` is low, nothing is stored. `in_y` stays below 254.
- R3: Inside the window, output columns `X0+2k` and `X0+2k+1` both carry source column k (X0 = 3).
- R4: Inside the window, output rows `Y0+3j`, `Y0+3j+1` and `Y0+3j+2` all carry source line j, read from ring slot `j mod 4` (Y0 = 3).
- R5: For an output position with `out_active` low, or with x outside [3, 1021) or y outside [3, 765), `pix_out` is 2'b00 and `pix_valid` is 0.
- R6: `pix_out`, `pix_valid`, `pix_x` and `pix_y` refer to the `out_*` inputs sampled one `rd_clk` edge earlier.
- R7: The ring holds 4 lines: writing source line j+4 replaces line j, and later reads of slot `j mod 4` return the new line.
- R8: While `rd_rst_n` is low on a `rd_clk` edge, the block leaves `pix_valid` at 0, `pix_out` at 2'b00 and `pix_x`/`pix_y` at 0. Reset is synchronous and active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source sampling clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, source side; blocks writes |
| in_valid | input | 1 | Write strobe for one source pixel |
| in_x | input | 9 | Source column, 0..511 |
| in_y | input | 8 | Source line number, 0..253 |
| in_pix | input | 2 | Source pixel code |
| rd_clk | input | 1 | Output pixel clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, output side |
| out_active | input | 1 | Output raster is in active video |
| out_x | input | 11 | Output raster column |
| out_y | input | 10 | Output raster row |
| pix_out | output | 2 | Upscaled pixel, black outside the window |
| pix_valid | output | 1 | `pix_out` lies inside the scaled window |
| pix_x | output | 11 | Column that `pix_out` belongs to |
| pix_y | output | 10 | Row that `pix_out` belongs to |

## Verification
Every output result is due on the first `rd_clk` rising edge after the raster position is presented: the pixel, the valid flag and the echoed position. A write lands on the first `wr_clk` edge after it is presented, and any read presented after that edge sees it. The bench drives every input on a falling edge and compares the outputs on the next falling edge against a prediction kept from the previous drive, so each comparison falls half a cycle after the register that produced it. Complete output rows are scanned, which covers the window edges on both sides. The rows cover line tripling, ring overwrite, the bottom edge of the window and randomly dropped active video.

// File: rtl/lbuf_pkg.sv
// Shared pixel type and code values for the line-buffered upscaler.
// Assumes 2-bit pixels; code 2'b10 is unused by the source.
package lbuf_pkg;
    typedef logic [1:0] pix_t;
    localparam pix_t PIX_BLACK = 2'b00;
    localparam pix_t PIX_LOW   = 2'b01;
    localparam pix_t PIX_HIGH  = 2'b11;
    localparam pix_t PIX_BAD   = 2'b10;
endpackage

// File: rtl/lbuf_ram.sv
// Two-clock simple dual-port memory holding the line ring.
// One write port on wr_clk and one registered read port on rd_clk.
// Assumes the caller never reads and writes the same word on the same edge.
module lbuf_ram #(
    parameter int AW = 11,
    parameter int DW = 2,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // store one word per write strobe
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read, one clock of latency
    always_ff @(posedge rd_clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lbuf_wr.sv
// Write side: forms the ring address from the source line and column.
// Assumes in_y stays below the source height and pixels use legal codes.
module lbuf_wr
    import lbuf_pkg::*;
#(
    parameter int XW    = 9,
    parameter int YSW   = 8,
    parameter int RW    = 2,
    parameter int SRC_H = 254,
    localparam int AW   = RW + XW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [XW-1:0]  in_x,
    input  logic [YSW-1:0] in_y,
    input  pix_t           in_pix,
    output logic           we,
    output logic [AW-1:0]  waddr,
    output pix_t           wdata
);
    logic unused_wr;

    // slot = low line bits, writes blocked in reset
    assign we        = in_valid && rst_n;
    assign waddr     = {in_y[RW-1:0], in_x};
    assign wdata     = in_pix;
    assign unused_wr = ^in_y[YSW-1:RW];

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_pix != PIX_BAD); // R1
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_y < YSW'(SRC_H)); // R2
endmodule

// File: rtl/lbuf_rd.sv
// Read side: maps an output raster position to a ring address by
// dividing x by the horizontal repeat and y by the vertical repeat,
// and blanks everything outside the scaled window.
// Assumes the reader stays 2 to 3 source lines behind the writer.
module lbuf_rd
    import lbuf_pkg::*;
#(
    parameter int SRC_W = 509,
    parameter int SRC_H = 254,
    parameter int H_REP = 2,
    parameter int V_REP = 3,
    parameter int X0    = 3,
    parameter int Y0    = 3,
    parameter int OXW   = 11,
    parameter int OYW   = 10,
    parameter int XW    = 9,
    parameter int RW    = 2,
    localparam int AW   = RW + XW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           out_active,
    input  logic [OXW-1:0] out_x,
    input  logic [OYW-1:0] out_y,
    output logic [AW-1:0]  raddr,
    input  pix_t           rdata,
    output pix_t           pix_out,
    output logic           pix_valid,
    output logic [OXW-1:0] pix_x,
    output logic [OYW-1:0] pix_y
);
    localparam logic [OXW-1:0] XLO = OXW'(X0);
    localparam logic [OXW-1:0] XHI = OXW'(X0 + H_REP * SRC_W);
    localparam logic [OYW-1:0] YLO = OYW'(Y0);
    localparam logic [OYW-1:0] YHI = OYW'(Y0 + V_REP * SRC_H);

    logic [OXW-1:0] dx, sx;
    logic [OYW-1:0] dy, sy;
    logic           in_win;
    logic           unused_rd;

    // source coordinates and ring address
    assign dx        = out_x - XLO;
    assign dy        = out_y - YLO;
    assign sx        = dx / OXW'(H_REP);
    assign sy        = dy / OYW'(V_REP);
    assign raddr     = {sy[RW-1:0], sx[XW-1:0]};
    assign unused_rd = ^{sx[OXW-1:XW], sy[OYW-1:RW]};

    // window test on the incoming position
    assign in_win = out_active && (out_x >= XLO) && (out_x < XHI)
                    && (out_y >= YLO) && (out_y < YHI);

    // align valid and position with the memory latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_x     <= '0;
            pix_y     <= '0;
        end else begin
            pix_valid <= in_win;
            pix_x     <= out_x;
            pix_y     <= out_y;
        end
    end

    // black outside the window
    assign pix_out = pix_valid ? rdata : PIX_BLACK;

    AST_BLACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |=> (pix_out == PIX_BLACK) && !pix_valid); // R5
    AST_POS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pix_x == $past(out_x)) && (pix_y == $past(out_y))); // R6
    AST_PAIR_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && pix_y == $past(pix_y)
         && pix_x == $past(pix_x) + 1'b1 && ((pix_x - XLO) & 1) == 1)
        |-> pix_out == $past(pix_out)); // R3
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !pix_valid && pix_out == PIX_BLACK); // R8
endmodule

// File: rtl/lbuf_upscaler.sv
// Top of the 2x3 upscaler: write side, line ring memory, read side.
// Assumes input and output frames are locked, with the output raster
// trailing the source by 2 to 3 source lines.
module lbuf_upscaler
    import lbuf_pkg::*;
#(
    parameter int SRC_W      = 509,
    parameter int SRC_H      = 254,
    parameter int LINE_SLOTS = 512,
    parameter int RING       = 4,
    parameter int H_REP      = 2,
    parameter int V_REP      = 3,
    parameter int X0         = 3,
    parameter int Y0         = 3,
    parameter int OXW        = 11,
    parameter int OYW        = 10,
    parameter int YSW        = 8,
    localparam int XW        = $clog2(LINE_SLOTS),
    localparam int RW        = $clog2(RING),
    localparam int AW        = RW + XW
) (
    input  logic           wr_clk,
    input  logic           wr_rst_n,
    input  logic           in_valid,
    input  logic [XW-1:0]  in_x,
    input  logic [YSW-1:0] in_y,
    input  logic [1:0]     in_pix,
    input  logic           rd_clk,
    input  logic           rd_rst_n,
    input  logic           out_active,
    input  logic [OXW-1:0] out_x,
    input  logic [OYW-1:0] out_y,
    output logic [1:0]     pix_out,
    output logic           pix_valid,
    output logic [OXW-1:0] pix_x,
    output logic [OYW-1:0] pix_y
);
    logic          we;
    logic [AW-1:0] waddr, raddr;
    pix_t          wdata, rdata;

    lbuf_wr #(.XW(XW), .YSW(YSW), .RW(RW), .SRC_H(SRC_H)) i_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .in_x(in_x),
        .in_y(in_y), .in_pix(in_pix), .we(we), .waddr(waddr), .wdata(wdata)
    );

    lbuf_ram #(.AW(AW), .DW(2)) i_ram (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .rd_clk(rd_clk), .raddr(raddr), .rdata(rdata)
    );

    lbuf_rd #(
        .SRC_W(SRC_W), .SRC_H(SRC_H), .H_REP(H_REP), .V_REP(V_REP),
        .X0(X0), .Y0(Y0), .OXW(OXW), .OYW(OYW), .XW(XW), .RW(RW)
    ) i_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .out_active(out_active),
        .out_x(out_x), .out_y(out_y), .raddr(raddr), .rdata(rdata),
        .pix_out(pix_out), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y)
    );
endmodule

// File: tb/test_lbuf_upscaler.sv
// Bench: random line contents with directed window edges, ring overwrite,
// ignored writes and dropped active video, checked against a bench model.
module test_lbuf_upscaler;
    localparam int X0 = 3, Y0 = 3, SW = 509, SH = 254;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [8:0]  in_x;
    logic [7:0]  in_y;
    logic [1:0]  in_pix;
    logic        out_active;
    logic [10:0] out_x;
    logic [9:0]  out_y;
    logic [1:0]  pix_out;
    logic        pix_valid;
    logic [10:0] pix_x;
    logic [9:0]  pix_y;

    int checks = 0, errors = 0;
    logic [1:0] model [4][512];
    logic       pend = 1'b0;
    logic [1:0] e_pix;
    logic       e_vld;
    logic [10:0] e_x;
    logic [9:0]  e_y;
    string      e_tag;

    always #4 clk = ~clk;

    lbuf_upscaler i_lbuf_upscaler (
        .wr_clk(clk), .wr_rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .in_y(in_y), .in_pix(in_pix), .rd_clk(clk), .rd_rst_n(rst_n),
        .out_active(out_active), .out_x(out_x), .out_y(out_y),
        .pix_out(pix_out), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y)
    );

    function automatic logic [1:0] rnd_pix();
        case ($urandom % 3)
            0: return 2'b00;
            1: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic win(input logic act, input int x, input int y);
        return act && x >= X0 && x < X0 + 2 * SW && y >= Y0 && y < Y0 + 3 * SH;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // compare outputs against the prediction of the previous drive
    task automatic settle();
        if (pend) begin
            check({e_tag, " pix"}, int'(pix_out), int'(e_pix));
            check("R5 valid", int'(pix_valid), int'(e_vld));
            check("R6 pos", int'({pix_x, pix_y}), int'({e_x, e_y}));
        end
    endtask

    task automatic write_line(input int y);
        for (int x = 0; x < 512; x++) begin
            @(negedge clk);
            settle(); pend = 1'b0;
            in_valid = 1'b1; in_x = 9'(x); in_y = 8'(y); in_pix = rnd_pix();
            model[y % 4][x] = in_pix;
        end
        @(negedge clk); in_valid = 1'b0;
    endtask

    // scan one output row; drop active video when sparse is set
    task automatic read_row(input int y, input string tag, input logic sparse);
        for (int x = 0; x < 1024; x++) begin
            logic act;
            @(negedge clk);
            settle();
            act = sparse ? (($urandom % 16) != 0) : 1'b1;
            out_active = act; out_x = 11'(x); out_y = 10'(y);
            e_vld = win(act, x, y);
            e_pix = e_vld ? model[((y - Y0) / 3) % 4][(x - X0) / 2] : 2'b00;
            e_x = 11'(x); e_y = 10'(y);
            e_tag = !e_vld ? "R5" : (((x - X0) % 2) == 1 ? "R3" : tag);
            pend = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd77));
        rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0; in_pix = '0;
        out_active = 1'b1; out_x = 11'd40; out_y = 10'd40;
        repeat (5) @(negedge clk);
        check("R8 reset valid", int'(pix_valid), 0);
        check("R8 reset pix", int'(pix_out), 0);
        check("R8 reset pos", int'({pix_x, pix_y}), 0);
        rst_n = 1'b1;

        // four fresh lines, then an ignored write to line 1 column 20
        for (int y = 0; y < 4; y++) write_line(y);
        @(negedge clk);
        in_valid = 1'b0; in_y = 8'd1; in_x = 9'd20;
        in_pix = ~model[1][20] | 2'b01;
        @(negedge clk);
        for (int y = 0; y < Y0 + 13; y++) read_row(y, "R4", 1'b0);
        @(negedge clk); settle(); pend = 1'b0;

        // R2: direct look at output columns of source column 20, line 1
        @(negedge clk);
        out_active = 1'b1; out_x = 11'(X0 + 40); out_y = 10'(Y0 + 3);
        @(negedge clk);
        check("R2 ignored write", int'(pix_out), int'(model[1][20]));

        // ring overwrite with lines 4..7, sparse active video
        for (int y = 4; y < 8; y++) write_line(y);
        for (int y = Y0 + 12; y < Y0 + 24; y++) read_row(y, "R7", 1'b1);
        @(negedge clk); settle(); pend = 1'b0;

        // last source lines and the rows below the window
        write_line(252); write_line(253);
        for (int y = Y0 + 756; y < 771; y++) read_row(y, "R4", 1'b0);
        @(negedge clk); settle(); pend = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule